// File: doc/BRIEF.md
# SPI ADC Acquisition Controller

This controller runs one conversion on an external eight-input, 10-bit successive-approximation converter reached over a four-wire serial link. A conversion request arrives on a valid/ready handshake together with a 3-bit input number and a single-ended or differential choice. The controller then pulls the select line low and clocks out a five-bit command: a start marker, the mode flag and the input number. It leaves one serial period for the converter to sample, skips one null bit, and shifts in the 10 result bits, most significant first. The result is presented as a parallel word with a one-clock strobe. The returned code is 1024 times the input voltage over the reference voltage, truncated to 10 bits.

The serial clock comes from the system clock through a divider. Each serial half period lasts `HALF_DIV` system clocks, so a full transaction takes 18 serial periods. That is 36·`HALF_DIV` system clocks, and the serial clock must therefore run at 18 times the wanted sample rate or faster. The request side applies back-pressure: `req_ready` is low for the whole transaction, and a request offered in that time is not taken. The sample side has no back-pressure. `smp_valid` is a single-cycle strobe and `smp_data` holds its value until the next result.

Top module: `adc_spi_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `spi_csn` is 1, while `spi_sclk`, `spi_mosi`, `busy` and `smp_valid` are 0 and `req_ready` is 1.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 whenever `busy` is 1. A request offered while busy changes neither the frame in progress nor starts an extra frame.
- R3: `spi_csn` goes low at the edge that takes the request and stays low for exactly 36·HALF_DIV clocks. It returns high only together with the result strobe.
- R4: `spi_sclk` is 0 whenever `spi_csn` is 1. During a frame it runs 18 periods of 2·HALF_DIV clocks each, with the low half first.
- R5: During serial period 0, `spi_mosi` carries the start bit, which is 1.
- R6: During serial period 1, `spi_mosi` carries the mode: 1 for single-ended (`req_single`=1), 0 for differential.
- R7: During periods 2, 3 and 4, `spi_mosi` carries channel bits 2, 1 and 0. It is 0 in periods 5 to 17 and while idle. It changes only when `spi_sclk` falls, or at the start or end of a frame.
- R8: `spi_miso` is sampled on the rising serial edge of periods 7 to 16, with the value from period 7 as bit 9. Its value during period 5 (sampling gap) and period 6 (null bit) does not affect the result.
- R9: `smp_valid` is high for exactly one clock, in the cycle after the edge that ends period 17. `smp_data` then holds the assembled word and keeps it until the next strobe.
- R10: `busy` is 1 from the cycle in which `spi_csn` goes low until the strobe is issued. It falls in the same cycle that `smp_valid` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Controller can take a request |
| req_chan | input | 3 | Converter input number |
| req_single | input | 1 | 1 single-ended, 0 differential |
| spi_csn | output | 1 | Active-low converter select |
| spi_sclk | output | 1 | Serial clock to the converter |
| spi_mosi | output | 1 | Serial command line |
| spi_miso | input | 1 | Serial result line from the converter |
| busy | output | 1 | Transaction in progress |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_data | output | 10 | Assembled result word |

## Verification
Assertions check the cycle-level invariants on every clock: the serial clock idles low while select is high, and the command line holds steady except at falling serial edges. They also check that select and busy only end together with a strobe that lasts exactly one clock, and that the divider count stays in range. The bench's reference model shows what the assertions cannot: the command bits placed in each period for different modes and inputs, and the assembled value of the result word. The scenarios also cover requests ignored mid-frame, back-to-back frames under a held request, and noise on the data line during the sampling gap and null bit.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int CH_W = 3;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_MODE,
    PH_CH2,
    PH_CH1,
    PH_CH0,
    PH_SAMPLE,
    PH_NULL,
    PH_DATA,
    PH_TAIL
  } phase_t;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          term;

  assign term     = (cnt == CW'(HALF_DIV - 1));
  assign rise_now = run && term && !sclk_q;
  assign fall_now = run && term && sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HALF_DIV - 1));
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             miso,
  output logic [RES_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word <= '0;
    else if (capture) word <= {word[RES_W-2:0], miso};
  end
endmodule

// File: rtl/adc_spi_ctrl.sv
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int RES_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic             req_single,
  output logic             spi_csn,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             busy,
  output logic             smp_valid,
  output logic [RES_W-1:0] smp_data
);
  localparam int BC_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  phase_t            state, nxt;
  logic              mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [BC_W-1:0]   bit_q;
  logic              csn_q, mosi_q, valid_q, cmd_bit;
  logic [RES_W-1:0]  data_q, word;
  logic              run, accept, rise_now, fall_now, bit_last;

  assign run       = (state != PH_IDLE);
  assign accept    = req_valid && !run;
  assign bit_last  = (bit_q == BC_W'(RES_W - 1));
  assign req_ready = !run;
  assign busy      = run;
  assign spi_csn   = csn_q;
  assign spi_mosi  = mosi_q;
  assign smp_valid = valid_q;
  assign smp_data  = data_q;

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(spi_sclk), .rise_now(rise_now), .fall_now(fall_now)
  );

  adc_rx_shift #(.RES_W(RES_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .capture(rise_now && state == PH_DATA),
    .miso(spi_miso), .word(word)
  );

  always_comb begin
    case (state)
      PH_START:  nxt = PH_MODE;
      PH_MODE:   nxt = PH_CH2;
      PH_CH2:    nxt = PH_CH1;
      PH_CH1:    nxt = PH_CH0;
      PH_CH0:    nxt = PH_SAMPLE;
      PH_SAMPLE: nxt = PH_NULL;
      PH_NULL:   nxt = PH_DATA;
      PH_DATA:   nxt = bit_last ? PH_TAIL : PH_DATA;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      PH_START: cmd_bit = 1'b1;
      PH_MODE:  cmd_bit = mode_q;
      PH_CH2:   cmd_bit = chan_q[2];
      PH_CH1:   cmd_bit = chan_q[1];
      PH_CH0:   cmd_bit = chan_q[0];
      default:  cmd_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      csn_q   <= 1'b1;
      mosi_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      bit_q   <= '0;
      mode_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (state == PH_IDLE) begin
        if (accept) begin
          state  <= PH_START;
          csn_q  <= 1'b0;
          mosi_q <= 1'b1;
          mode_q <= req_single;
          chan_q <= req_chan;
          bit_q  <= '0;
        end
      end else if (fall_now) begin
        state  <= nxt;
        mosi_q <= cmd_bit;
        if (state == PH_DATA) bit_q <= bit_q + 1'b1;
        if (state == PH_TAIL) begin
          csn_q   <= 1'b1;
          valid_q <= 1'b1;
          data_q  <= word;
        end
      end
    end
  end

  // R4
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk);
  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && $past(!spi_csn) && !$fell(spi_sclk)) |-> $stable(spi_mosi));
  // R3
  csn_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_csn) |-> smp_valid);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> smp_valid);
endmodule

// File: tb/adc_spi_ctrl_test.sv
`timescale 1ns/1ps
module adc_spi_ctrl_test;
  localparam int H     = 3;
  localparam int RES_W = 10;
  localparam int FRAME = 36 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_single = 1'b0, spi_miso = 1'b1;
  logic [2:0] req_chan = '0;
  logic req_ready, spi_csn, spi_sclk, spi_mosi, busy, smp_valid;
  logic [RES_W-1:0] smp_data;

  int n_chk = 0, n_fail = 0;

  // behavioural reference state
  bit m_busy = 0, m_valid = 0, m_mode = 0;
  int m_t = 0;
  logic [2:0] m_chan = '0;
  logic [RES_W-1:0] m_code = '0, m_data = '0, next_code = '0;

  always #4 clk = ~clk;

  adc_spi_ctrl #(.HALF_DIV(H), .RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_single(req_single), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int p;
    int e_mosi;
    p = m_t / (2 * H);
    e_mosi = 0;
    if (m_busy) begin
      case (p)
        0: e_mosi = 1;
        1: e_mosi = m_mode;
        2: e_mosi = m_chan[2];
        3: e_mosi = m_chan[1];
        4: e_mosi = m_chan[0];
        default: e_mosi = 0;
      endcase
    end
    chk("R3 csn", spi_csn, !m_busy);
    chk("R4 sclk", spi_sclk, m_busy ? int'((m_t % (2 * H)) >= H) : 0);
    if (m_busy && p == 0)      chk("R5 start bit", spi_mosi, e_mosi);
    else if (m_busy && p == 1) chk("R6 mode bit", spi_mosi, e_mosi);
    else                       chk("R7 mosi", spi_mosi, e_mosi);
    chk("R10 busy", busy, m_busy);
    chk("R2 ready", req_ready, !m_busy);
    chk("R9 valid", smp_valid, m_valid);
    chk("R8 data", smp_data, m_data);
  endtask

  task automatic step();
    int kn, p;
    spi_miso = 1'b1;   // noise outside the result bits
    if (m_busy) begin
      kn = m_t + 1;
      p = kn / (2 * H);
      if (p >= 7 && p <= 16) spi_miso = m_code[RES_W - 1 - (p - 7)];
    end
    @(posedge clk);
    if (m_busy) begin
      m_t++;
      m_valid = 0;
      if (m_t == FRAME) begin
        m_busy = 0; m_valid = 1; m_data = m_code;
      end
    end else begin
      m_valid = 0;
      if (req_valid) begin
        m_busy = 1; m_t = 0; m_mode = req_single; m_chan = req_chan; m_code = next_code;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic frame(input bit single, input logic [2:0] ch, input logic [RES_W-1:0] code);
    next_code = code;
    req_single = single;
    req_chan = ch;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    for (int i = 0; i < FRAME + 3; i++) step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 csn", spi_csn, 1);
    chk("R1 sclk", spi_sclk, 0);
    chk("R1 mosi", spi_mosi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 valid", smp_valid, 0);
    chk("R1 ready", req_ready, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    frame(1'b1, 3'd5, 10'h2A5);   // R5 R6 R7 R8 single-ended
    frame(1'b0, 3'd2, 10'h000);   // R8 noise in gap and null bit
    frame(1'b1, 3'd7, 10'h3FF);
    frame(1'b0, 3'd0, 10'h155);

    // R2: requests offered mid-frame are ignored
    next_code = 10'h0F3;
    req_single = 1'b1; req_chan = 3'd6; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) step();
    next_code = 10'h111;
    req_single = 1'b0; req_chan = 3'd1; req_valid = 1'b1;
    for (int i = 0; i < 30; i++) step();
    req_valid = 1'b0;
    for (int i = 0; i < FRAME; i++) step();

    // R9 R10: held request gives back-to-back frames
    next_code = 10'h2C6;
    req_single = 1'b1; req_chan = 3'd3; req_valid = 1'b1;
    for (int i = 0; i < FRAME + 2; i++) step();
    next_code = 10'h01B;
    for (int i = 0; i < FRAME / 2; i++) step();
    req_valid = 1'b0;
    for (int i = 0; i < FRAME; i++) step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule